// File: doc/BRIEF.md
# Double-Width Restoring Integer Divider

This block divides a dividend of twice the result width, presented as an upper and a lower half, by a divisor of the result width. It produces a quotient and a remainder of the result width. A mode input selects unsigned or two's-complement signed arithmetic. One shift-subtract step is taken per clock, so a full division takes a fixed number of cycles set by the width parameter `W`. A divide-error flag reports a zero divisor or a quotient that cannot be represented. When the error is raised, the previous quotient and remainder are kept.

In signed mode the operands are first turned into magnitudes: the dividend is negated across its full double width, and the divisor is negated. The unsigned core then runs on these magnitudes. Signs are applied afterwards, with a range check that depends on the sign of the quotient. Before any iteration, the upper half of the dividend magnitude is compared with the divisor magnitude. When the upper half is not smaller, the quotient cannot fit, so the block reports the error at once and skips the iteration.

The control is a five-state machine:

- `ST_IDLE` waits for `start_i`.
- `ST_CHECK` loads the magnitudes and makes the early decision. It goes to `ST_DONE` on a zero divisor or an early overflow, and to `ST_RUN` otherwise.
- `ST_RUN` takes `W` steps, then goes to `ST_FIX`.
- `ST_FIX` applies the signs and the range check, then goes to `ST_DONE`.
- `ST_DONE` raises `done_o` for one cycle, then returns to `ST_IDLE`.

Top module: `div_restoring`

## Requirements
- R1: A divisor of zero sets `div_err_o`. `done_o` rises after the first clock edge following the edge that samples `start_i`.
- R2: When the magnitude of the dividend's upper half is greater than or equal to the divisor magnitude, the error is raised on the same early timing as R1, with no iteration.
- R3: In unsigned mode (`signed_i`=0), `quotient_o` is the floor of {hi,lo}/divisor and `remainder_o` is the rest. A true quotient above 2^W-1 sets `div_err_o`.
- R4: Any division not stopped early delivers `done_o` after edge W+2, counting the edge that samples `start_i` as edge 0.
- R5: In signed mode (`signed_i`=1), the quotient is truncated toward zero and the remainder carries the sign of the dividend.
- R6: In signed mode with differing operand signs, a magnitude quotient of up to 2^(W-1) is accepted, so -2^(W-1) is a valid result. With equal signs, the quotient must be below 2^(W-1). Beyond these limits `div_err_o` is set.
- R7: `done_o` is high for exactly one cycle per accepted start. `busy_o` is high from the cycle after the start edge through the `done_o` cycle.
- R8: When `div_err_o` is set, `quotient_o` and `remainder_o` keep the values of the last successful division (zero after reset).
- R9: `start_i` is ignored while `busy_o` is high. It does not change the running result and does not produce an extra `done_o`.
- R10: A synchronous reset (`rst`=1) returns the block to idle, with `busy_o`, `done_o` and `div_err_o` low, and the quotient and remainder zero.
- R11: `packed_o` carries the remainder in its upper W bits and the quotient in its lower W bits. For W=8, these are the upper and lower byte of a 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a division (accepted when idle) |
| signed_i | input | 1 | 1 = signed, 0 = unsigned |
| dividend_hi_i | input | W | Upper half of the dividend |
| dividend_lo_i | input | W | Lower half of the dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error, valid from done until the next start |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |
| packed_o | output | 2*W | {remainder, quotient} |

## Verification
Each result is due a fixed number of clock edges after the edge that samples `start_i`. The result comes after one edge when the zero-divisor check or the early overflow check fires, and after W+2 edges otherwise. This includes late overflows that are caught only after sign fixing. The driver records the number of the sampling edge and pushes the expected latency with the expected values. The monitor samples on falling edges, and when it sees `done_o` it compares the measured edge distance with the expected one. The quotient, remainder, error flag and packed word are compared in that same cycle.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
// Converts the operands to magnitudes and makes the early error decision.
module div_sign_prep #(
    parameter int W = 8
) (
    input  logic           signed_i,
    input  logic [W-1:0]   num_hi_i,
    input  logic [W-1:0]   num_lo_i,
    input  logic [W-1:0]   den_i,
    output logic [2*W-1:0] mag_num_o,
    output logic [W-1:0]   mag_den_o,
    output logic           neg_num_o,
    output logic           neg_den_o,
    output logic           den_zero_o,
    output logic           early_ovf_o
);
    localparam int NUM_W = 2 * W;

    logic [NUM_W-1:0] num;

    always_comb begin
        num         = {num_hi_i, num_lo_i};
        neg_num_o   = signed_i & num[NUM_W-1];
        neg_den_o   = signed_i & den_i[W-1];
        mag_num_o   = neg_num_o ? (~num + NUM_W'(1)) : num;
        mag_den_o   = neg_den_o ? (~den_i + W'(1)) : den_i;
        den_zero_o  = (den_i == '0);
        // Upper half at or above the divisor means the quotient needs more than W bits.
        early_ovf_o = (mag_num_o[NUM_W-1:W] >= mag_den_o);
    end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract step.
module div_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic       take;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        // The bit shifted out of the remainder is included in the compare.
        take    = (shifted >= {1'b0, den_i});
        rem_o   = take ? (shifted[W-1:0] - den_i) : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], take};
    end
endmodule

// File: rtl/div_sign_fix.sv
// Applies result signs and checks the signed range.
module div_sign_fix #(
    parameter int W = 8
) (
    input  logic         signed_i,
    input  logic         neg_num_i,
    input  logic         neg_den_i,
    input  logic [W-1:0] mag_q_i,
    input  logic [W-1:0] mag_r_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o,
    output logic         range_err_o
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic differ;

    always_comb begin
        differ      = neg_num_i ^ neg_den_i;
        range_err_o = signed_i & (differ ? (mag_q_i > HALF) : (mag_q_i >= HALF));
        q_o         = differ ? (~mag_q_i + W'(1)) : mag_q_i;
        r_o         = neg_num_i ? (~mag_r_i + W'(1)) : mag_r_i;
    end
endmodule

// File: rtl/div_restoring.sv
module div_restoring
    import div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   dividend_hi_i,
    input  logic [W-1:0]   dividend_lo_i,
    input  logic [W-1:0]   divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           div_err_o,
    output logic [W-1:0]   quotient_o,
    output logic [W-1:0]   remainder_o,
    output logic [2*W-1:0] packed_o
);
    localparam int              NUM_W     = 2 * W;
    localparam int              CNT_W     = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    div_state_e state_q, state_d;

    logic [W-1:0]     op_hi, op_lo, op_den;
    logic             op_signed;
    logic [W-1:0]     work_rem, work_quo;
    logic [CNT_W-1:0] step_cnt;
    logic [W-1:0]     q_r, r_r;
    logic             err_r;

    logic [NUM_W-1:0] mag_num;
    logic [W-1:0]     mag_den;
    logic             neg_num, neg_den, den_zero, early_ovf;
    logic [W-1:0]     rem_n, quo_n;
    logic [W-1:0]     fix_q, fix_r;
    logic             range_err;

    div_sign_prep #(.W(W)) u_prep (
        .signed_i    (op_signed),
        .num_hi_i    (op_hi),
        .num_lo_i    (op_lo),
        .den_i       (op_den),
        .mag_num_o   (mag_num),
        .mag_den_o   (mag_den),
        .neg_num_o   (neg_num),
        .neg_den_o   (neg_den),
        .den_zero_o  (den_zero),
        .early_ovf_o (early_ovf)
    );

    div_step #(.W(W)) u_step (
        .rem_i (work_rem),
        .quo_i (work_quo),
        .den_i (mag_den),
        .rem_o (rem_n),
        .quo_o (quo_n)
    );

    div_sign_fix #(.W(W)) u_fix (
        .signed_i    (op_signed),
        .neg_num_i   (neg_num),
        .neg_den_i   (neg_den),
        .mag_q_i     (work_quo),
        .mag_r_i     (work_rem),
        .q_o         (fix_q),
        .r_o         (fix_r),
        .range_err_o (range_err)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CHECK;
            ST_CHECK: state_d = (den_zero || early_ovf) ? ST_DONE : ST_RUN;
            ST_RUN:   if (step_cnt == LAST_STEP) state_d = ST_FIX;
            ST_FIX:   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_hi     <= '0;
            op_lo     <= '0;
            op_den    <= '0;
            op_signed <= 1'b0;
            work_rem  <= '0;
            work_quo  <= '0;
            step_cnt  <= '0;
            q_r       <= '0;
            r_r       <= '0;
            err_r     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_hi     <= dividend_hi_i;
                        op_lo     <= dividend_lo_i;
                        op_den    <= divisor_i;
                        op_signed <= signed_i;
                        err_r     <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    work_rem <= mag_num[NUM_W-1:W];
                    work_quo <= mag_num[W-1:0];
                    step_cnt <= '0;
                    if (den_zero || early_ovf) begin
                        err_r <= 1'b1;
                    end
                end
                ST_RUN: begin
                    work_rem <= rem_n;
                    work_quo <= quo_n;
                    step_cnt <= step_cnt + CNT_W'(1);
                end
                ST_FIX: begin
                    if (range_err) begin
                        err_r <= 1'b1;
                    end else begin
                        q_r <= fix_q;
                        r_r <= fix_r;
                    end
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign div_err_o   = err_r;
    assign quotient_o  = q_r;
    assign remainder_o = r_r;
    assign packed_o    = {r_r, q_r};
endmodule

// File: rtl/div_restoring_chk.sv
module div_restoring_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         div_err_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o
);
    // R7: completion pulse lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: done only while the operation is still marked busy
    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R1: the error flag appears only together with completion
    p_err_with_done_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(div_err_o) |-> done_o);

    // R8: results hold when an error completes
    p_hold_on_err_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_err_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

    // R9: results do not move while an operation is running
    p_stable_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

    // R7: an idle start makes the block busy
    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);
endmodule

bind div_restoring div_restoring_chk #(.W(W)) u_chk (.*);

// File: tb/sim_div_restoring.sv
`timescale 1ns/1ps
module sim_div_restoring;
    localparam int W    = 8;
    localparam int FULL = W + 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic           signed_i = 1'b0;
    logic [W-1:0]   dividend_hi_i = '0;
    logic [W-1:0]   dividend_lo_i = '0;
    logic [W-1:0]   divisor_i = '0;
    logic           busy_o, done_o, div_err_o;
    logic [W-1:0]   quotient_o, remainder_o;
    logic [2*W-1:0] packed_o;

    div_restoring #(.W(W)) u0 (.*);

    initial forever #4 clk = ~clk;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         err;
        int           lat;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    int           start_cyc = 0;
    logic [W-1:0] mdl_q = '0;
    logic [W-1:0] mdl_r = '0;
    bit           ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic finish_sim();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reference model pushing expected results
    task automatic run_div(input bit s, input logic [W-1:0] hi, input logic [W-1:0] lo,
                           input logic [W-1:0] den, input string tag, input bit poke);
        longint n, d, magn, magd, qq, rr;
        bit     early, err;
        exp_t   e;
        if (s) begin
            n = longint'($signed({hi, lo}));
            d = longint'($signed(den));
        end else begin
            n = longint'({hi, lo});
            d = longint'(den);
        end
        magn  = (n < 0) ? -n : n;
        magd  = (d < 0) ? -d : d;
        early = (d == 0) || ((magn >> W) >= magd);
        err   = 0;
        qq    = 0;
        rr    = 0;
        if (d == 0) begin
            err = 1;
        end else begin
            qq = n / d;
            rr = n % d;
            if (s) err = (qq > (1 << (W - 1)) - 1) || (qq < -(1 << (W - 1)));
            else   err = (qq > (1 << W) - 1);
        end
        if (!err) begin
            mdl_q = qq[W-1:0];
            mdl_r = rr[W-1:0];
        end
        e.q = mdl_q; e.r = mdl_r; e.err = err;
        e.lat = early ? 1 : FULL; e.tag = tag;
        sb.push_back(e);

        while (busy_o) @(negedge clk);
        start_i = 1'b1; signed_i = s;
        dividend_hi_i = hi; dividend_lo_i = lo; divisor_i = den;
        start_cyc = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start_i = 1'b1; signed_i = ~s;
            dividend_hi_i = 8'h00; dividend_lo_i = 8'h05; divisor_i = 8'h01;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor
    initial forever begin
        @(negedge clk);
        if (done_o) begin
            if (sb.size() == 0) begin
                check(0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient_o == e.q && remainder_o == e.r, {e.tag, " q/r"},
                      {remainder_o, quotient_o}, {e.r, e.q});
                check(div_err_o == e.err, {e.tag, " err"}, div_err_o, e.err);
                check((cyc - start_cyc) == e.lat, {e.tag, " R4 latency"}, cyc - start_cyc, e.lat);
                check(packed_o == {e.r, e.q}, {e.tag, " R11 packed"}, packed_o, {e.r, e.q});
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !div_err_o && quotient_o == 0 && remainder_o == 0,
              "R10 reset state", {busy_o, done_o, div_err_o}, 0);

        // Unsigned
        run_div(0, 8'h00, 8'h64, 8'h07, "R3 u 100/7", 0);
        run_div(0, 8'h12, 8'h34, 8'h56, "R3 u 0x1234/0x56", 0);
        run_div(0, 8'h00, 8'hFF, 8'h01, "R3 u 255/1 max", 0);
        run_div(0, 8'h11, 8'h34, 8'h12, "R3 u hi just below divisor", 0);
        run_div(0, 8'h12, 8'h34, 8'h12, "R2 u hi equals divisor", 0);
        run_div(0, 8'hFF, 8'hFF, 8'hFF, "R2 u all ones", 0);
        run_div(0, 8'h01, 8'h00, 8'h00, "R1 R8 zero divisor", 0);

        // Signed
        run_div(1, 8'hFF, 8'h9C, 8'h07, "R5 s -100/7", 0);
        run_div(1, 8'h00, 8'h64, 8'hF9, "R5 s 100/-7", 0);
        run_div(1, 8'hFF, 8'h9C, 8'hF9, "R5 s -100/-7", 0);
        run_div(1, 8'hFF, 8'h00, 8'h02, "R6 s -256/2 gives -128", 0);
        run_div(1, 8'h01, 8'h00, 8'h02, "R6 R8 s 256/2 overflow", 0);
        run_div(1, 8'hFF, 8'h00, 8'hFE, "R6 s -256/-2 overflow", 0);
        run_div(1, 8'h80, 8'h00, 8'hFF, "R2 s min/-1 early", 0);
        run_div(1, 8'h00, 8'h00, 8'h00, "R1 s zero divisor", 0);

        // Start while busy
        run_div(0, 8'h03, 8'hE8, 8'h0A, "R9 u 1000/10 with poke", 1);
        run_div(1, 8'hFC, 8'h18, 8'h0A, "R9 s -1000/10 with poke", 1);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9 R7 queue drained, no extra done", sb.size(), 0);

        // Reset during a running division
        start_i = 1'b1; signed_i = 1'b0;
        dividend_hi_i = 8'h00; dividend_lo_i = 8'h40; divisor_i = 8'h03;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_q = '0; mdl_r = '0;
        @(negedge clk);
        check(!busy_o && !done_o && !div_err_o && quotient_o == 0 && remainder_o == 0,
              "R10 reset mid-run", {busy_o, done_o, div_err_o, quotient_o}, 0);
        repeat (FULL + 2) @(negedge clk);
        check(!done_o && !busy_o, "R10 no completion after reset", done_o, 0);

        run_div(0, 8'h00, 8'h40, 8'h03, "R3 u 64/3 after reset", 0);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
        finish_sim();
    end
endmodule